// File: doc/BRIEF.md
# Three-Wire Codec Control Serializer

This block is a bus master for a three-wire codec control link made of a mode line, a clock line and a data line. A host hands it one byte at a time together with a transfer kind and a one-cycle start strobe. An address transfer frames the byte with the mode line low. A data transfer frames it with the mode line high. A data transfer with halt first holds the link in a halt gap before the data framing begins. The host sees `busy` while a byte is on the wire and a one-cycle `done` when the lines are back at rest.

Every interval on the link is a whole number of system-clock cycles. These counts come from the system clock frequency and the minimum times given in nanoseconds, and they are rounded up so that no minimum is ever undercut. Bytes leave the block least significant bit first. The clock rests high, so the codec samples each bit on a rising clock edge.

A package supplies helpers that build the control bytes the codec expects. An address byte puts the device identifier 000101 in bits 7:2 and a target code in bits 1:0. The status sub-register A byte packs the reset, clock-ratio, audio-format and DC-filter fields.

Top module: `tw_ctl_ser`

## Requirements
- R1: While `rst` is sampled high and in the cycle after, the lines rest at clock 1, mode 1 and data 0, with `busy` 0 and `done` 0.
- R2: An address transfer (kind 00) opens with SETUP_CYC cycles at clock 1, mode 0 and data 0, and holds mode 0 until its last bit ends. SETUP_CYC is the smallest count whose length is at least SETUP_NS (190 ns); at 250 MHz it is 48.
- R3: A data transfer holds mode 1 for the whole byte, including a SETUP_CYC-cycle opening at clock 1 and data 0.
- R4: Each transfer sends exactly 8 bits, bit 0 first and bit 7 last.
- R5: Each bit drives clock 0 with data equal to the bit for HALF_CYC cycles, then clock 1 with the same data for HALF_CYC cycles. HALF_CYC is the smallest count for which two halves last longer than BIT_NS (500 ns); at 250 MHz it is 63.
- R6: Kind 10 (data with halt) puts HALT_CYC cycles of clock 1, mode 0 and data 0 (at least HALT_NS, 190 ns; 48 at 250 MHz) before the data opening of R3.
- R7: Kind codes are 00 address, 01 data and 10 data with halt. Code 11 behaves as plain data.
- R8: The cycle after the last bit's high half, the lines return to clock 1, mode 1 and data 0, and `done` is 1 for exactly that one cycle.
- R9: A start strobe seen while `busy` is 1 has no effect on the lines or on the byte being sent. A start strobe in the `done` cycle is accepted.
- R10: `busy` is 1 from the cycle after an accepted start through the last bit's high half, and 0 otherwise.
- R11: The address helper returns {000101, target}, with targets 00 data0, 01 data1 and 10 status. The status-A helper returns {0, reset, ratio[1:0], format[2:0], dc_filter}.
- R12: A reset during a transfer returns the lines to idle in the next cycle with `busy` 0 and `done` 0, and the byte in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request strobe |
| kind_i | input | 2 | Transfer kind: 00 address, 01 data, 10 data with halt, 11 data |
| byte_i | input | 8 | Byte to send, captured with the strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the lines return to idle |
| ctl_clk_o | output | 1 | Link clock line, rests high |
| ctl_mode_o | output | 1 | Link mode line: low for address, high for data |
| ctl_dat_o | output | 1 | Link data line |

## Verification
A wrong phase, a wrong bit index or a miscounted interval inside the block shows up as a level on the clock, mode or data line that differs from the expected waveform. The reference model compares the whole waveform cycle by cycle, so such a mismatch is reported in the first clock cycle in which the wrong level appears. A kind or byte wrongly latched by an ignored strobe shows up as a wrong mode level or bit value during the ongoing transfer. A done pulse that is late, lost or doubled is caught in the cycle where the lines come back to idle.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;

    typedef enum logic [1:0] {
        KIND_ADDR      = 2'b00,
        KIND_DATA      = 2'b01,
        KIND_DATA_HALT = 2'b10,
        KIND_DATA_ALT  = 2'b11
    } xfer_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HALT,
        PH_SETUP,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   is_data;
        logic   done;
    } ctl_state_t;

    localparam logic [5:0] DEV_ID = 6'b000101;

    localparam logic [1:0] TGT_DATA0  = 2'b00;
    localparam logic [1:0] TGT_DATA1  = 2'b01;
    localparam logic [1:0] TGT_STATUS = 2'b10;

    // R11: address byte = identifier in the top six bits, target code below
    function automatic logic [7:0] addr_byte(input logic [1:0] tgt);
        return {DEV_ID, tgt};
    endfunction

    // R11: status sub-register A (bit 7 = 0 selects A)
    function automatic logic [7:0] status_a_byte(input logic       rst_bit,
                                                 input logic [1:0] clk_ratio,
                                                 input logic [2:0] fmt,
                                                 input logic       dc_filt);
        return {1'b0, rst_bit, clk_ratio, fmt, dc_filt};
    endfunction

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/tw_bit_shifter.sv
module tw_bit_shifter #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NBITS-1:0] load_byte,
    input  logic             advance,
    output logic             bit_o,
    output logic             last_o
);
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

    typedef struct packed {
        logic [NBITS-1:0] sh;
        logic [IW-1:0]    idx;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh  = load_byte;
            s_d.idx = '0;
        end else if (advance) begin
            s_d.sh  = s_q.sh >> 1;
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign bit_o  = s_q.sh[0];
    assign last_o = (s_q.idx == IW'(NBITS - 1));

    // R4: the sequencer never asks for a ninth bit
    assert_no_extra_shift_R4: assert property (@(posedge clk) disable iff (rst)
        advance |-> !last_o);

    // R4: a reload and a shift never coincide
    assert_load_excl_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> !advance);

endmodule

// File: rtl/tw_ctl_ser.sv
module tw_ctl_ser
    import tw_ctl_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int SETUP_NS = 190,
    parameter int HALT_NS  = 190,
    parameter int BIT_NS   = 500,
    parameter int NBITS    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       kind_i,
    input  logic [NBITS-1:0] byte_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ctl_clk_o,
    output logic             ctl_mode_o,
    output logic             ctl_dat_o
);
    localparam int SETUP_RAW = (SETUP_NS * CLK_MHZ + 999) / 1000;
    localparam int HALT_RAW  = (HALT_NS * CLK_MHZ + 999) / 1000;
    localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
    localparam int HALT_CYC  = (HALT_RAW < 1) ? 1 : HALT_RAW;
    localparam int HALF_CYC  = (BIT_NS * CLK_MHZ) / 2000 + 1;
    localparam int MAX_A     = (SETUP_CYC > HALT_CYC) ? SETUP_CYC : HALT_CYC;
    localparam int MAX_CYC   = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
    localparam int TW        = $clog2(MAX_CYC + 1);

    localparam ctl_state_t RST_STATE = '{phase: PH_IDLE, is_data: 1'b0, done: 1'b0};

    ctl_state_t st_d, st_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          sh_load;
    logic          sh_adv;
    logic          sh_bit;
    logic          sh_last;
    xfer_kind_e    kind;

    assign kind = xfer_kind_e'(kind_i);

    tw_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    tw_bit_shifter #(.NBITS(NBITS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (byte_i),
        .advance   (sh_adv),
        .bit_o     (sh_bit),
        .last_o    (sh_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sh_load   = 1'b0;
        sh_adv    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.is_data = (kind != KIND_ADDR);
                    sh_load      = 1'b1;
                    tmr_load     = 1'b1;
                    if (kind == KIND_DATA_HALT) begin
                        st_d.phase = PH_HALT;
                        tmr_val    = TW'(HALT_CYC - 1);
                    end else begin
                        st_d.phase = PH_SETUP;
                        tmr_val    = TW'(SETUP_CYC - 1);
                    end
                end
            end
            PH_HALT: begin
                if (tmr_zero) begin
                    st_d.phase = PH_SETUP;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(SETUP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    st_d.phase = PH_LOW;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(HALF_CYC - 1);
                end
            end
            PH_LOW: begin
                if (tmr_zero) begin
                    st_d.phase = PH_HIGH;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(HALF_CYC - 1);
                end
            end
            PH_HIGH: begin
                if (tmr_zero) begin
                    if (sh_last) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_LOW;
                        sh_adv     = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(HALF_CYC - 1);
                    end
                end
            end
            default: st_d = RST_STATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_STATE;
        else     st_q <= st_d;
    end

    // line levels decoded from the registered phase
    always_comb begin
        ctl_clk_o  = 1'b1;
        ctl_mode_o = 1'b1;
        ctl_dat_o  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE:  ;
            PH_HALT:  ctl_mode_o = 1'b0;
            PH_SETUP: ctl_mode_o = st_q.is_data;
            PH_LOW: begin
                ctl_clk_o  = 1'b0;
                ctl_mode_o = st_q.is_data;
                ctl_dat_o  = sh_bit;
            end
            PH_HIGH: begin
                ctl_mode_o = st_q.is_data;
                ctl_dat_o  = sh_bit;
            end
            default: ;
        endcase
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign done_o = st_q.done;

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: done only appears with the lines at rest
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ctl_clk_o && ctl_mode_o && !ctl_dat_o && !busy_o));

    // R5: data is held across the rising clock edge
    assert_hold_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $rose(ctl_clk_o)) |-> $stable(ctl_dat_o));

    // R2: the clock only goes low inside a transfer
    assert_clk_low_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !ctl_clk_o |-> busy_o);

    // R3: the mode line does not move once framing has begun
    assert_mode_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && st_q.phase != PH_HALT && $past(st_q.phase) != PH_HALT)
        |-> $stable(ctl_mode_o));

    // R9: a strobe during a transfer leaves the latched framing alone
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(st_q.is_data));

endmodule

// File: tb/tw_ctl_ser_bench.sv
module tw_ctl_ser_bench;
    import tw_ctl_pkg::*;

    localparam int PERIOD_NS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] kind = 2'b00;
    logic [7:0] byte_v = 8'h00;
    logic       busy, done, l_clk, l_mode, l_dat;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    typedef struct packed {
        logic       c;
        logic       m;
        logic       d;
        logic [3:0] tag;
    } smp_t;

    smp_t exp_q[$];
    bit   cur_busy  = 1'b0;
    bit   pend_done = 1'b0;
    int   setup_n, halt_n, half_n;

    always #2 clk = ~clk;

    tw_ctl_ser u_tw_ctl_ser (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .kind_i     (kind),
        .byte_i     (byte_v),
        .busy_o     (busy),
        .done_o     (done),
        .ctl_clk_o  (l_clk),
        .ctl_mode_o (l_mode),
        .ctl_dat_o  (l_dat)
    );

    function automatic int at_least(int ns);
        int n = 1;
        while (n * PERIOD_NS < ns) n++;
        return n;
    endfunction

    function automatic int half_for(int ns);
        int h = 1;
        while (2 * h * PERIOD_NS <= ns) h++;
        return h;
    endfunction

    function automatic string rtag(logic [3:0] t);
        case (t)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // expected waveform of one transfer, one entry per clock cycle
    task automatic push_xfer(input logic [1:0] k, input logic [7:0] b);
        logic       md = (k != 2'b00);
        logic [3:0] stag = (k == 2'b11) ? 4'd7 : (md ? 4'd3 : 4'd2);
        if (k == 2'b10)
            repeat (halt_n) exp_q.push_back('{1'b1, 1'b0, 1'b0, 4'd6});
        repeat (setup_n) exp_q.push_back('{1'b1, md, 1'b0, stag});
        for (int i = 0; i < 8; i++) begin
            repeat (half_n) exp_q.push_back('{1'b0, md, b[i], 4'd4});
            repeat (half_n) exp_q.push_back('{1'b1, md, b[i], 4'd5});
        end
    endtask

    // model accepts requests on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            pend_done = 1'b0;
        end else if (start && !cur_busy) begin
            push_xfer(kind, byte_v);
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        smp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            cur_busy = 1'b1;
            chk({l_clk, l_mode, l_dat} == {e.c, e.m, e.d},
                {rtag(e.tag), " lines"}, {l_clk, l_mode, l_dat}, {e.c, e.m, e.d});
            chk(busy && !done, "R10 busy/done in transfer", {busy, done}, 2'b10);
            if (exp_q.size() == 0) pend_done = 1'b1;
        end else begin
            cur_busy = 1'b0;
            chk({l_clk, l_mode, l_dat, busy, done} == {3'b110, 1'b0, pend_done},
                "R8 idle lines, R10 busy, done pulse",
                {l_clk, l_mode, l_dat, busy, done}, {3'b110, 1'b0, pend_done});
            pend_done = 1'b0;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            nchk++;
            nerr++;
            $display("FAIL R8 watchdog expired actual=%0d expected<=200000", cyc);
            summary();
            $finish;
        end
    end

    task automatic send(input logic [1:0] k, input logic [7:0] b);
        start  = 1'b1;
        kind   = k;
        byte_v = b;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    initial begin
        setup_n = at_least(190);
        halt_n  = at_least(190);
        half_n  = half_for(500);

        // R11: helper encodings
        chk(addr_byte(TGT_STATUS) == 8'h16, "R11 status address", addr_byte(TGT_STATUS), 8'h16);
        chk(addr_byte(TGT_DATA0) == 8'h14, "R11 data0 address", addr_byte(TGT_DATA0), 8'h14);
        chk(addr_byte(TGT_DATA1) == 8'h15, "R11 data1 address", addr_byte(TGT_DATA1), 8'h15);
        chk(status_a_byte(1'b1, 2'b10, 3'b001, 1'b1) == 8'h63, "R11 status A",
            status_a_byte(1'b1, 2'b10, 3'b001, 1'b1), 8'h63);

        repeat (3) @(negedge clk);
        // R1: rest levels under reset
        chk({l_clk, l_mode, l_dat, busy, done} == 5'b11000, "R1 reset state",
            {l_clk, l_mode, l_dat, busy, done}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        chk({l_clk, l_mode, l_dat, busy, done} == 5'b11000, "R1 after reset",
            {l_clk, l_mode, l_dat, busy, done}, 5'b11000);

        // R2, R4: address byte
        send(2'b00, addr_byte(TGT_STATUS));
        repeat (60) @(negedge clk);
        // R9: strobe while busy has no effect; mode must stay low
        send(2'b01, 8'hFF);
        chk(busy && !l_mode, "R9 ignored strobe", {busy, l_mode}, 2'b10);

        // R9: strobe in the done cycle is accepted; R3 data byte
        wait_done();
        send(2'b01, status_a_byte(1'b0, 2'b01, 3'b000, 1'b1));
        chk(busy && l_mode, "R9 accept in done cycle", {busy, l_mode}, 2'b11);

        // R6: data with halt
        wait_done();
        send(2'b10, 8'hA5);

        // R7: code 11 behaves as data
        wait_done();
        send(2'b11, 8'h81);

        wait_done();
        repeat (5) @(negedge clk);
        send(2'b01, 8'h00);
        wait_done();
        send(2'b00, 8'hFF);

        // R12: reset mid-transfer
        repeat (300) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({l_clk, l_mode, l_dat, busy, done} == 5'b11000, "R12 reset mid-transfer",
            {l_clk, l_mode, l_dat, busy, done}, 5'b11000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        send(2'b01, 8'h3C);
        wait_done();
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end

endmodule